// File: doc/BRIEF.md
# Card Clock Divider with Glitch-Free Gating

This block derives the clock for a memory card from a reference clock. Software programs a 10-bit division ratio, turns the internal divider on, and polls a read-only stable flag. It sets the card clock enable only after the flag reads 1. Even and odd ratios both give a clean period. Ratios 0 and 1 skip the divider, so the reference clock itself drives the card. The block gates the card output so that no shortened pulse ever reaches the pin.

The control word is a plain 32-bit register with a single-cycle write strobe and a continuous read-back. It has no data stream and no handshake. Any change of ratio clears the stable flag. So does clearing the internal enable. The flag comes back only after a fixed number of divided-clock rising edges. A ratio written while the card clock is enabled waits until the enable is cleared and the output has gone quiet.

Top module: `card_clk_gen`

## Requirements
- R1: After reset, every bit of `rd_data` is 0 and `card_clk` is 0.
- R2: The register map is as follows. Bit 0 is the internal enable and bit 2 is the card clock enable. Bits 15:6 read back the last written ratio and bit 1 is the stable flag. Bits 31:16 and 5:3, including the clock generator select at bit 5, always read 0.
- R3: For an applied ratio N from 2 to 1023, `card_clk` has a period of N reference cycles. It is high for floor(N/2) cycles and low for ceil(N/2) cycles.
- R4: For an applied ratio of 0 or 1, the enabled `card_clk` follows the reference clock. It is high while the reference is high and low while it is low.
- R5: While the internal enable is 0, the divider is stopped and `card_clk` stays 0. The stable flag reads 0 from the second cycle onward.
- R6: The stable flag clears in the cycle after a new ratio is applied. It rises only after SETTLE_EDGES rising edges of the divided clock, counted from the enable or from the applied change.
- R7: `card_clk` is gated on only while the card enable, the internal enable and the stable flag are all 1. In divide mode the gate switches only while the divided clock is low, so every pulse has its full width.
- R8: A ratio written while the card enable is 1 is shown in the read-back at once, but it does not affect `card_clk`. It is applied only after the card enable is cleared and the gate has closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control and status read-back |
| card_clk | output | 1 | Gated clock to the card |

## Verification
Two functions can meet in the same cycle. One is the application of a pending ratio, which restarts the stable count. The other is the card gate, which must not open on a stale stable flag or close in the middle of a pulse. The bench provokes this in two ways. It writes a new ratio while the card clock runs, then clears the enable. It also sets both enables in a single write. It then judges the pulse widths before and after the ratio takes effect, and it confirms that `card_clk` stays low in every cycle the stable flag reads 0.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned RATIO_W   = 10;
  localparam int unsigned BIT_ICE   = 0;
  localparam int unsigned BIT_STBL  = 1;
  localparam int unsigned BIT_CEN   = 2;
  localparam int unsigned RATIO_LSB = 6;
  localparam int unsigned RATIO_MSB = RATIO_LSB + RATIO_W - 1;
endpackage

// File: rtl/ccg_regs.sv
module ccg_regs
  import ccg_pkg::*;
#(
  parameter int unsigned RW = RATIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              stable,
  input  logic              out_off,
  output logic              ice,
  output logic              cen,
  output logic [RW-1:0]     ratio_act,
  output logic              ratio_chg,
  output logic [WORD_W-1:0] rd_data
);
  logic [RW-1:0] ratio_req;
  logic          apply_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ice       <= 1'b0;
      cen       <= 1'b0;
      ratio_req <= '0;
    end else if (wr_en) begin
      ice       <= wr_data[BIT_ICE];
      cen       <= wr_data[BIT_CEN];
      ratio_req <= wr_data[RATIO_LSB +: RW];
    end
  end

  // a pending ratio moves in only once the card gate is fully closed
  assign apply_ok  = !cen && out_off;
  assign ratio_chg = apply_ok && (ratio_req != ratio_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ratio_act <= '0;
    else if (ratio_chg) ratio_act <= ratio_req;
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[BIT_ICE]               = ice;
    rd_data[BIT_STBL]              = stable;
    rd_data[BIT_CEN]               = cen;
    rd_data[RATIO_LSB +: RW]       = ratio_req;
  end
endmodule

// File: rtl/ccg_div.sv
module ccg_div #(
  parameter int unsigned RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ice,
  input  logic [RW-1:0] ratio,
  output logic          bypass,
  output logic          div_q,
  output logic          low_next,
  output logic          rise
);
  logic [RW-1:0] cnt_q, cnt_d, last, half;
  logic          div_d;

  always_comb begin
    bypass   = (ratio < RW'(2));
    half     = ratio >> 1;
    last     = ratio - RW'(1);
    cnt_d    = (cnt_q >= last) ? '0 : cnt_q + RW'(1);
    div_d    = ice && !bypass && (cnt_d < half);
    rise     = ice && (bypass || (cnt_d == '0));
    low_next = !div_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= (!ice || bypass) ? '0 : cnt_d;
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/ccg_settle.sv
module ccg_settle #(
  parameter int unsigned SETTLE_EDGES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ice,
  input  logic restart,
  input  logic rise,
  output logic stable
);
  localparam int unsigned CW = $clog2(SETTLE_EDGES + 1);
  localparam logic [CW-1:0] TARGET = CW'(SETTLE_EDGES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stable <= 1'b0;
    end else if (!ice || restart) begin
      cnt_q  <= '0;
      stable <= 1'b0;
    end else if (!stable && rise) begin
      cnt_q  <= cnt_q + CW'(1);
      if (cnt_q + CW'(1) == TARGET) stable <= 1'b1;
    end
  end
endmodule

// File: rtl/ccg_gate.sv
module ccg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic bypass,
  input  logic div_q,
  input  logic low_next,
  output logic gate_q,
  output logic gate_n,
  output logic out_off,
  output logic card_clk
);
  // divide mode: the gate moves only on an edge after which the clock is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gate_q <= 1'b0;
    else if (bypass)   gate_q <= 1'b0;
    else if (low_next) gate_q <= allow;
  end

  // bypass mode: the gate moves on the falling reference edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_n <= 1'b0;
    else        gate_n <= bypass && allow;
  end

  assign out_off  = !gate_q && !gate_n;
  assign card_clk = bypass ? (clk && gate_n) : (div_q && gate_q);
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import ccg_pkg::*;
#(
  parameter int unsigned SETTLE_EDGES = 8
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              card_clk
);
  logic              ice_w, cen_w, stable_w, chg_w, off_w;
  logic [RATIO_W-1:0] ratio_act_w;
  logic              byp_w, div_w, low_next_w, rise_w;
  logic              gate_q_w, gate_n_w;

  ccg_regs #(.RW(RATIO_W)) u_regs (
    .clk(clk_ref), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stable(stable_w), .out_off(off_w), .ice(ice_w), .cen(cen_w),
    .ratio_act(ratio_act_w), .ratio_chg(chg_w), .rd_data(rd_data)
  );

  ccg_div #(.RW(RATIO_W)) u_div (
    .clk(clk_ref), .rst_n(rst_n), .ice(ice_w), .ratio(ratio_act_w),
    .bypass(byp_w), .div_q(div_w), .low_next(low_next_w), .rise(rise_w)
  );

  ccg_settle #(.SETTLE_EDGES(SETTLE_EDGES)) u_settle (
    .clk(clk_ref), .rst_n(rst_n), .ice(ice_w), .restart(chg_w),
    .rise(rise_w), .stable(stable_w)
  );

  ccg_gate u_gate (
    .clk(clk_ref), .rst_n(rst_n), .allow(cen_w && ice_w && stable_w),
    .bypass(byp_w), .div_q(div_w), .low_next(low_next_w),
    .gate_q(gate_q_w), .gate_n(gate_n_w), .out_off(off_w),
    .card_clk(card_clk)
  );
endmodule

// File: rtl/ccg_checker.sv
module ccg_checker #(
  parameter int unsigned RW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ice,
  input logic          cen,
  input logic          stable,
  input logic [RW-1:0] ratio_act,
  input logic          div_q,
  input logic          gate_q,
  input logic          gate_n
);
  a_r5_stable_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ice && $past(!ice)) |-> !stable);

  a_r5_div_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ice && $past(!ice)) |-> !div_q);

  a_r6_stable_needs_ice: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> ice);

  a_r7_gate_on_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> (stable && cen && ice));

  a_r7_bypass_gate_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_n) |-> (stable && cen && ice));

  a_r7_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> !div_q);

  a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    cen |=> $stable(ratio_act));
endmodule

bind card_clk_gen ccg_checker #(.RW(ccg_pkg::RATIO_W)) u_chk (
  .clk(clk_ref), .rst_n(rst_n), .ice(ice_w), .cen(cen_w), .stable(stable_w),
  .ratio_act(ratio_act_w), .div_q(div_w), .gate_q(gate_q_w), .gate_n(gate_n_w)
);

// File: tb/card_clk_gen_tb.sv
`timescale 1ns/1ps
module card_clk_gen_tb;
  logic        clk_ref = 1'b0;
  logic        rst_n   = 1'b0;
  logic        wr_en   = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        card_clk;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_ref = ~clk_ref;

  card_clk_gen u_dut (.clk_ref(clk_ref), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .card_clk(card_clk));

  // ratio, expected high cycles, expected low cycles (0 = bypass)
  localparam int NV = 9;
  localparam int VEC [NV][3] = '{
    '{2, 1, 1}, '{3, 1, 2}, '{4, 2, 2}, '{5, 2, 3}, '{7, 3, 4},
    '{10, 5, 5}, '{1, 0, 0}, '{0, 0, 0}, '{1023, 511, 512}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int ratio, input bit cen, input bit ice);
    return {16'b0, 10'(ratio), 3'b0, cen, 1'b0, ice};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk_ref); wr_en = 1'b1; wr_data = d;
    @(negedge clk_ref); wr_en = 1'b0;
  endtask

  task automatic wait_stable(output int cyc);
    cyc = 0;
    while (!rd_data[1] && cyc < 20000) begin @(negedge clk_ref); cyc++; end
  endtask

  task automatic measure(output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    while (card_clk && g < 3000) begin @(negedge clk_ref); g++; end
    while (!card_clk && g < 3000) begin @(negedge clk_ref); g++; end
    while (card_clk && g < 3000) begin @(negedge clk_ref); hi++; g++; end
    while (!card_clk && g < 3000) begin @(negedge clk_ref); lo++; g++; end
  endtask

  task automatic check_bypass(input string req);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_ref); #1;
      check(card_clk == 1'b1, req, card_clk, 1);
      @(negedge clk_ref); #1;
      check(card_clk == 1'b0, req, card_clk, 0);
    end
  endtask

  initial begin
    #(190000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo, cyc, n;
    repeat (3) @(negedge clk_ref);
    // R1 reset state
    check(rd_data == 32'h0, "R1", rd_data, 0);
    check(card_clk == 1'b0, "R1", card_clk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_ref);

    // table walk: R3, R4, R6
    for (int i = 0; i < NV; i++) begin
      n = VEC[i][0];
      wr(word(n, 0, 1));
      @(negedge clk_ref);
      check(rd_data[1] == 1'b0, "R6 drop", rd_data[1], 0);
      wait_stable(cyc);
      if (n < 2) check(cyc >= 6 && cyc <= 12, "R6 settle", cyc, 8);
      else       check(cyc >= 7 * n && cyc <= 9 * n + 4, "R6 settle", cyc, 8 * n);
      wr(word(n, 1, 1));
      if (n < 2) begin
        repeat (3) @(negedge clk_ref);
        check_bypass("R4");
      end else begin
        measure(hi, lo);
        check(hi == VEC[i][1], "R3 high", hi, VEC[i][1]);
        check(lo == VEC[i][2], "R3 low", lo, VEC[i][2]);
      end
      wr(word(n, 0, 1));
      repeat (n + 4) @(negedge clk_ref);
    end

    // R8: ratio written while card clock runs is held
    wr(word(4, 0, 1)); wait_stable(cyc);
    wr(word(4, 1, 1));
    wr(word(6, 1, 1));
    check(rd_data[15:6] == 10'd6, "R8 readback", rd_data[15:6], 6);
    measure(hi, lo);
    check(hi == 2 && lo == 2, "R8 held", hi * 10 + lo, 22);
    check(rd_data[1] == 1'b1, "R8 stable kept", rd_data[1], 1);
    wr(word(6, 0, 1));
    repeat (8) @(negedge clk_ref);
    check(rd_data[1] == 1'b0, "R8 applied R6", rd_data[1], 0);
    wait_stable(cyc);
    wr(word(6, 1, 1));
    measure(hi, lo);
    check(hi == 3 && lo == 3, "R8 new ratio", hi * 10 + lo, 33);

    // R5: internal enable off
    wr(word(6, 0, 0));
    repeat (8) @(negedge clk_ref);
    check(rd_data[1] == 1'b0, "R5 stable", rd_data[1], 0);
    begin
      int seen = 0;
      for (int k = 0; k < 40; k++) begin
        @(posedge clk_ref); #1; seen |= card_clk;
        @(negedge clk_ref); #1; seen |= card_clk;
      end
      check(seen == 0, "R5 stopped", seen, 0);
    end

    // R7: both enables in one write, clock must wait for stable
    wr(word(3, 0, 0));
    repeat (4) @(negedge clk_ref);
    wr(word(3, 1, 1));
    begin
      int bad = 0;
      for (int k = 0; k < 20000 && !rd_data[1]; k++) begin
        @(negedge clk_ref);
        if (!rd_data[1] && card_clk) bad++;
      end
      check(bad == 0, "R7 gated until stable", bad, 0);
    end
    measure(hi, lo);
    check(hi == 1 && lo == 2, "R7 full pulse", hi * 10 + lo, 12);

    // R2: read-only bits read zero
    wr(32'hFFFF_FFFF);
    @(negedge clk_ref);
    check((rd_data & 32'hFFFF_0038) == 0, "R2 ro zero", rd_data, 0);
    check(rd_data[15:6] == 10'h3FF, "R2 ratio field", rd_data[15:6], 1023);
    check(rd_data[0] && rd_data[2], "R2 enables", {rd_data[2], rd_data[0]}, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule